// File: doc/BRIEF.md
# Bipolar Transmit Line Coder

This block is the coding stage of one transmit channel of a digital line interface. It takes single-rail NRZ data, one bit per bit-clock enable, and drives a pair of registered rail outputs. A high level on the positive rail is a positive mark, a high level on the negative rail is a negative mark, and both rails low is a space. Ones are sent with alternating polarity. The block can switch in zero-substitution coding, either the eight-zero scheme or the four-zero scheme, which replaces long zero runs with patterns that contain deliberate polarity violations.

Coding is on when the global code control is set, or when the channel's own code control is set and the global one is clear. Dual-rail mode always forces coding off. A registered decode-enable output follows the same choice, so the receive side always matches the transmit side. An alarm request replaces the data with continuous alternating marks, unless remote loopback is active. Bits are normally timed by the transmit clock enable. When that clock is reported lost, alarm bits are timed from an internal reference instead. The reference is the external reference enable divided by 16, or the enable itself when the clock-select input says the reference already runs at sixteen times the rate.

Top module: `bpl_tx_coder`

## Requirements
- R1: Coding is enabled when `glb_code`=1 whatever `chan_code` holds. When `glb_code`=0, `chan_code` alone decides. `dec_en` shows the resolved choice one clock after the inputs change.
- R2: While `dual_rail`=1, coding is forced off: `dec_en` is 0, and zero runs of any length are sent as spaces.
- R3: With coding off, each one is sent as a mark of opposite polarity to the previous mark, and each zero as a space. The first mark after reset is positive (`pos_out`=1). `pos_out` and `neg_out` are never high together.
- R4: A bit presented at a bit tick reaches the rails at the eighth bit tick after it. After reset the first eight ticks emit spaces.
- R5: With coding on and `hdb3_sel`=0, every run of eight zeros is sent as 0,0,0,V,B,0,V,B. V is a mark of the same polarity as the mark before it. B is a mark of the opposite polarity to the mark before it.
- R6: With coding on and `hdb3_sel`=1, every run of four zeros is sent as 0,0,0,V if an odd number of marks has been sent since the last violation, and as B,0,0,V if that number is even. The count is even after reset.
- R7: While `ais_req`=1 and `rmt_loop`=0, ones are coded in place of `nrz_in`, whatever `nrz_in` holds.
- R8: While `rmt_loop`=1, `ais_req` has no effect and `nrz_in` is coded.
- R9: While `tx_clk_lost`=0, bit ticks are the `tx_clk_en` pulses. While `tx_clk_lost`=1 and the alarm is active, a tick occurs on every `ref_clk_en` pulse when `ref_x16_sel`=1, and on every 16th pulse when `ref_x16_sel`=0. While `tx_clk_lost`=1 and the alarm is inactive, no ticks occur and the rails hold.
- R10: The rails change only at a bit tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_clk_en | input | 1 | Bit enable from the transmit clock |
| tx_clk_lost | input | 1 | Transmit clock reported lost |
| ref_clk_en | input | 1 | Enable from the external reference clock |
| ref_x16_sel | input | 1 | 1: internal reference is 16x the external reference |
| nrz_in | input | 1 | Single-rail data bit |
| glb_code | input | 1 | Global coding override |
| chan_code | input | 1 | Per-channel coding select |
| hdb3_sel | input | 1 | 0: eight-zero substitution, 1: four-zero substitution |
| dual_rail | input | 1 | Dual-rail interface mode, which forces coding off |
| ais_req | input | 1 | Alarm indication request |
| rmt_loop | input | 1 | Remote loopback active |
| pos_out | output | 1 | Positive rail |
| neg_out | output | 1 | Negative rail |
| dec_en | output | 1 | Receive decode enable |

## Verification
The hardest state to reach from the ports is the fallback timing. It requires a lost transmit clock, an active alarm and a pipeline already full of marks, all at once. The stimulus first runs the alarm with the normal clock until the pipeline holds only marks. It then flags the clock lost and streams reference enables. Over a fixed window it counts rail transitions, and the count must match the divided rate for each setting of the clock select. Substitution patterns are checked against an array-based encoder in the bench, and against literal sequences for one known run in each scheme.

// File: rtl/bpl_pkg.sv
package bpl_pkg;
  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_MARK = 2'd1,
    SYM_VIOL = 2'd2
  } sym_e;
endpackage

// File: rtl/bpl_tick_gen.sv
module bpl_tick_gen #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_clk_en,
  input  logic tx_clk_lost,
  input  logic ref_clk_en,
  input  logic ref_x16_sel,
  input  logic ais_act,
  output logic bit_tick
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] div_q;
  logic          fb_tick;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else if (ref_clk_en) div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
  end

  always_comb begin
    fb_tick  = ref_clk_en & (ref_x16_sel | (div_q == LAST));
    bit_tick = tx_clk_lost ? (ais_act & fb_tick) : tx_clk_en;
  end
endmodule

// File: rtl/bpl_sub_pipe.sv
module bpl_sub_pipe
  import bpl_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic code_en,
  input  logic hdb3_sel,
  input  logic ais_act,
  input  logic nrz_in,
  output sym_e sym_out
);
  localparam int B8_LEN = 8;
  localparam int H3_LEN = 4;
  localparam int ZW = $clog2(B8_LEN + 1);

  sym_e          sr  [DEPTH];
  sym_e          nxt [DEPTH];
  logic [ZW-1:0] zrun, zrun_nxt, run_last;
  logic          par, par_nxt;
  logic          is_zero, sub_hit;

  always_comb begin
    run_last = hdb3_sel ? ZW'(H3_LEN - 1) : ZW'(B8_LEN - 1);
    is_zero  = ~ais_act & ~nrz_in;
    sub_hit  = code_en & is_zero & (zrun == run_last);
    nxt[0]   = is_zero ? SYM_ZERO : SYM_MARK;
    for (int i = 1; i < DEPTH; i++) nxt[i] = sr[i-1];
    par_nxt  = par ^ ~is_zero;
    zrun_nxt = (code_en & is_zero) ? zrun + 1'b1 : '0;
    if (sub_hit) begin
      zrun_nxt = '0;
      par_nxt  = 1'b0;
      if (hdb3_sel) begin
        nxt[0] = SYM_VIOL;
        nxt[3] = par ? SYM_ZERO : SYM_MARK;
      end else begin
        nxt[4] = SYM_VIOL;
        nxt[3] = SYM_MARK;
        nxt[1] = SYM_VIOL;
        nxt[0] = SYM_MARK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) sr[i] <= SYM_ZERO;
      zrun <= '0;
      par  <= 1'b0;
    end else if (bit_tick) begin
      for (int i = 0; i < DEPTH; i++) sr[i] <= nxt[i];
      zrun <= zrun_nxt;
      par  <= par_nxt;
    end
  end

  assign sym_out = sr[DEPTH-1];
endmodule

// File: rtl/bpl_rail_out.sv
module bpl_rail_out
  import bpl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  sym_e sym_in,
  output logic pos_out,
  output logic neg_out
);
  logic last_pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_out  <= 1'b0;
      neg_out  <= 1'b0;
      last_pos <= 1'b0;
    end else if (bit_tick) begin
      case (sym_in)
        SYM_MARK: begin
          pos_out  <= ~last_pos;
          neg_out  <= last_pos;
          last_pos <= ~last_pos;
        end
        SYM_VIOL: begin
          pos_out <= last_pos;
          neg_out <= ~last_pos;
        end
        default: begin
          pos_out <= 1'b0;
          neg_out <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/bpl_tx_coder.sv
module bpl_tx_coder
  import bpl_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int REF_DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_clk_en,
  input  logic tx_clk_lost,
  input  logic ref_clk_en,
  input  logic ref_x16_sel,
  input  logic nrz_in,
  input  logic glb_code,
  input  logic chan_code,
  input  logic hdb3_sel,
  input  logic dual_rail,
  input  logic ais_req,
  input  logic rmt_loop,
  output logic pos_out,
  output logic neg_out,
  output logic dec_en
);
  logic code_en, ais_act, bit_tick;
  sym_e pipe_sym;

  assign code_en = ~dual_rail & (glb_code | chan_code);
  assign ais_act = ais_req & ~rmt_loop;

  always_ff @(posedge clk) begin
    if (rst) dec_en <= 1'b0;
    else     dec_en <= code_en;
  end

  bpl_tick_gen #(.DIV(REF_DIV)) tick_i (
    .clk(clk), .rst(rst), .tx_clk_en(tx_clk_en), .tx_clk_lost(tx_clk_lost),
    .ref_clk_en(ref_clk_en), .ref_x16_sel(ref_x16_sel), .ais_act(ais_act),
    .bit_tick(bit_tick)
  );

  bpl_sub_pipe #(.DEPTH(DEPTH)) pipe_i (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .code_en(code_en),
    .hdb3_sel(hdb3_sel), .ais_act(ais_act), .nrz_in(nrz_in), .sym_out(pipe_sym)
  );

  bpl_rail_out rail_i (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .sym_in(pipe_sym),
    .pos_out(pos_out), .neg_out(neg_out)
  );
endmodule

// File: rtl/bpl_tx_coder_chk.sv
module bpl_tx_coder_chk (
  input logic clk,
  input logic rst,
  input logic tx_clk_en,
  input logic ref_clk_en,
  input logic glb_code,
  input logic dual_rail,
  input logic pos_out,
  input logic neg_out,
  input logic dec_en
);
  // R3
  rails_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pos_out && neg_out));

  // R2
  dual_off_chk: assert property (@(posedge clk) disable iff (rst)
    dual_rail |=> !dec_en);

  // R1
  glb_on_chk: assert property (@(posedge clk) disable iff (rst)
    (glb_code && !dual_rail) |=> dec_en);

  // R10
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_clk_en && !ref_clk_en) |=> $stable({pos_out, neg_out}));
endmodule

bind bpl_tx_coder bpl_tx_coder_chk chk_i (
  .clk(clk), .rst(rst), .tx_clk_en(tx_clk_en), .ref_clk_en(ref_clk_en),
  .glb_code(glb_code), .dual_rail(dual_rail), .pos_out(pos_out),
  .neg_out(neg_out), .dec_en(dec_en)
);

// File: tb/bpl_tx_coder_tb_top.sv
module bpl_tx_coder_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_clk_en = 0, tx_clk_lost = 0, ref_clk_en = 0, ref_x16_sel = 0;
  logic nrz_in = 0, glb_code = 0, chan_code = 0, hdb3_sel = 0, dual_rail = 0;
  logic ais_req = 0, rmt_loop = 0;
  logic pos_out, neg_out, dec_en;

  int checks = 0;
  int errors = 0;
  int in_bits [0:63];
  int kind    [0:79];
  logic exp_p [0:79];
  logic exp_n [0:79];
  logic got_p [0:79];
  logic got_n [0:79];

  always #2 clk = ~clk;

  bpl_tx_coder dut_i (
    .clk(clk), .rst(rst), .tx_clk_en(tx_clk_en), .tx_clk_lost(tx_clk_lost),
    .ref_clk_en(ref_clk_en), .ref_x16_sel(ref_x16_sel), .nrz_in(nrz_in),
    .glb_code(glb_code), .chan_code(chan_code), .hdb3_sel(hdb3_sel),
    .dual_rail(dual_rail), .ais_req(ais_req), .rmt_loop(rmt_loop),
    .pos_out(pos_out), .neg_out(neg_out), .dec_en(dec_en)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tx_clk_en = 0; ref_clk_en = 0; tx_clk_lost = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic tick_bit(input int b, input int idx);
    nrz_in = b[0]; tx_clk_en = 1'b1;
    @(negedge clk);
    tx_clk_en = 1'b0;
    got_p[idx] = pos_out; got_n[idx] = neg_out;
    @(negedge clk);
  endtask

  // Array-based reference encoder built from R3, R5, R6, R7.
  task automatic build_ref(input int n, input bit code, input bit h3, input bit ais);
    int zc = 0;
    bit par = 0;
    bit last = 0;
    for (int i = 0; i < n + 8; i++) begin
      int b = (i < n && !ais) ? in_bits[i] : 1;
      if (code && b == 0) begin
        zc++;
        kind[i] = 0;
        if (h3 && zc == 4) begin
          kind[i] = 2; kind[i-3] = par ? 0 : 1; par = 0; zc = 0;
        end else if (!h3 && zc == 8) begin
          kind[i-4] = 2; kind[i-3] = 1; kind[i-1] = 2; kind[i] = 1; zc = 0;
        end
      end else begin
        zc = 0;
        kind[i] = b;
        if (b != 0) par = ~par;
      end
    end
    for (int i = 0; i < n + 8; i++) begin
      case (kind[i])
        1: begin last = ~last; exp_p[i] = last; exp_n[i] = ~last; end
        2: begin exp_p[i] = last; exp_n[i] = ~last; end
        default: begin exp_p[i] = 0; exp_n[i] = 0; end
      endcase
    end
  endtask

  task automatic run_compare(input int n, input bit code, input bit ais, input string req);
    build_ref(n, code, hdb3_sel, ais);
    for (int j = 0; j < n + 8; j++) tick_bit((j < n) ? in_bits[j] : 1, j);
    for (int j = 0; j < n + 8; j++) begin
      int ep = (j < 8) ? 0 : exp_p[j-8];
      int en = (j < 8) ? 0 : exp_n[j-8];
      check({req, " pos"}, got_p[j], ep);
      check({req, " neg"}, got_n[j], en);
    end
  endtask

  task automatic load_run_pattern();
    for (int i = 0; i < 64; i++) in_bits[i] = 1;
    in_bits[0] = 1;
    for (int i = 1; i <= 8; i++) in_bits[i] = 0;
    for (int i = 10; i < 22; i++) in_bits[i] = 0;
    in_bits[25] = 0; in_bits[26] = 0; in_bits[27] = 0;
    for (int i = 30; i < 35; i++) in_bits[i] = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    check("R3 reset pos", pos_out, 0);
    check("R3 reset neg", neg_out, 0);
    check("R1 reset dec_en", dec_en, 0);
  endtask

  task automatic t_code_select();
    glb_code = 1; chan_code = 0; dual_rail = 0;
    @(negedge clk); check("R1 global on", dec_en, 1);
    glb_code = 0; chan_code = 1;
    @(negedge clk); check("R1 channel on", dec_en, 1);
    chan_code = 0;
    @(negedge clk); check("R1 both off", dec_en, 0);
    glb_code = 1; chan_code = 1; dual_rail = 1;
    @(negedge clk); check("R2 dual forces off", dec_en, 0);
    dual_rail = 0; glb_code = 0; chan_code = 0;
  endtask

  task automatic t_ami();
    glb_code = 0; chan_code = 0; dual_rail = 0; hdb3_sel = 0;
    do_reset();
    load_run_pattern();
    run_compare(40, 0, 0, "R3/R4 plain marks");
  endtask

  task automatic t_b8zs();
    glb_code = 0; chan_code = 1; hdb3_sel = 0; dual_rail = 0;
    do_reset();
    load_run_pattern();
    run_compare(40, 1, 0, "R5 eight-zero");
    // literal: bits 0..9 = 1,0x8,1 -> +,0,0,0,+,-,0,-,+,-
    check("R5 literal V1", {got_p[12], got_n[12]}, 2'b10);
    check("R5 literal B1", {got_p[13], got_n[13]}, 2'b01);
    check("R5 literal V2", {got_p[15], got_n[15]}, 2'b01);
    check("R5 literal B2", {got_p[16], got_n[16]}, 2'b10);
  endtask

  task automatic t_hdb3();
    glb_code = 1; chan_code = 0; hdb3_sel = 1; dual_rail = 0;
    do_reset();
    load_run_pattern();
    run_compare(40, 1, 0, "R6 four-zero");
    // literal: 1,0000,0000,1 -> +,0,0,0,+,-,0,0,-,+
    check("R6 literal 000V", {got_p[12], got_n[12]}, 2'b10);
    check("R6 literal B", {got_p[13], got_n[13]}, 2'b01);
    check("R6 literal V", {got_p[16], got_n[16]}, 2'b01);
  endtask

  task automatic t_dual();
    glb_code = 1; chan_code = 1; hdb3_sel = 1; dual_rail = 1;
    do_reset();
    load_run_pattern();
    run_compare(40, 0, 0, "R2 dual no substitution");
    dual_rail = 0;
  endtask

  task automatic t_ais();
    glb_code = 1; hdb3_sel = 0; ais_req = 1; rmt_loop = 0;
    do_reset();
    for (int i = 0; i < 64; i++) in_bits[i] = 0;
    run_compare(20, 1, 1, "R7 alarm marks");
    ais_req = 0;
  endtask

  task automatic t_loop();
    glb_code = 1; hdb3_sel = 1; ais_req = 1; rmt_loop = 1;
    do_reset();
    load_run_pattern();
    run_compare(40, 1, 0, "R8 loopback blocks alarm");
    ais_req = 0; rmt_loop = 0;
  endtask

  task automatic t_fallback();
    int changes;
    logic [1:0] prev;
    glb_code = 0; chan_code = 0; ais_req = 1; rmt_loop = 0;
    do_reset();
    for (int j = 0; j < 12; j++) tick_bit(0, j);
    tx_clk_lost = 1; ref_clk_en = 1; ref_x16_sel = 0;
    repeat (40) @(negedge clk);
    prev = {pos_out, neg_out}; changes = 0;
    for (int k = 0; k < 160; k++) begin
      @(negedge clk);
      if ({pos_out, neg_out} != prev) changes++;
      prev = {pos_out, neg_out};
    end
    check("R9 divided reference ticks", changes, 10);
    ref_x16_sel = 1;
    @(negedge clk);
    prev = {pos_out, neg_out}; changes = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if ({pos_out, neg_out} != prev) changes++;
      prev = {pos_out, neg_out};
    end
    check("R9 undivided reference ticks", changes, 20);
    ais_req = 0; ref_x16_sel = 0;
    @(negedge clk);
    prev = {pos_out, neg_out}; changes = 0;
    tx_clk_en = 1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if ({pos_out, neg_out} != prev) changes++;
    end
    tx_clk_en = 0; ref_clk_en = 0; tx_clk_lost = 0;
    check("R9 lost clock without alarm holds", changes, 0);
  endtask

  task automatic t_hold();
    int changes = 0;
    logic [1:0] prev;
    glb_code = 0; chan_code = 0;
    do_reset();
    for (int j = 0; j < 9; j++) tick_bit(1, j);
    prev = {pos_out, neg_out};
    nrz_in = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if ({pos_out, neg_out} != prev) changes++;
    end
    check("R10 rails hold between ticks", changes, 0);
    check("R10 rail nonzero held", prev, 2'b10);
  endtask

  bit done = 0;

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_code_select();
    t_ami();
    t_b8zs();
    t_hdb3();
    t_dual();
    t_ais();
    t_loop();
    t_fallback();
    t_hold();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule